// File: doc/BRIEF.md
# Multi-Column Two-Phase Clock Generator

This block drives a pair of non-overlapping phase clocks, plus a column clock, for each of several switched-capacitor columns. Each column watches one of four source enables (two global system sources, two auxiliary sources that digital blocks drive). It divides the chosen source by four. The first phase is high for one source period. A dead source period follows, then the second phase is high for one source period, then another dead source period. The column clock flips each time either phase drops.

All logic runs on one system clock. The sources arrive as single-cycle enable pulses, and every output comes straight from a flop. A bus write to either of two designated addresses restarts every column together, so columns that share a source come back in phase. The same write is the only moment when the per-column source selections are taken from `sel_i`.

Top module: `twophase_colclk`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first selected enable, all of `phi1_o`, `phi2_o` and `colclk_o` are low. Every column resets to source code 0.
- R2: Column c takes its source code from `sel_i[2c+1:2c]`. Code k selects `src_en_i[k]`: codes 0 and 1 are the global sources, 2 and 3 the auxiliary ones. Enables on the other sources do not move that column.
- R3: Each column steps a four-state sequence on every selected enable. `phi1_o` is high only after the 1st enable of a cycle and stays high until the 2nd. `phi2_o` is high only after the 3rd enable and stays high until the 4th. Four enables therefore give one rising edge of each phase.
- R4: In any column, `phi1_o` and `phi2_o` are never both high. Between the fall of one phase and the rise of the other there is at least one full source period.
- R5: A column's `colclk_o` toggles in exactly the cycle after a selected enable that makes `phi1_o` or `phi2_o` fall, and at no other time except a resync.
- R6: A write with `bus_we_i` high to `ADDR_SEL` or `ADDR_CAL` clears every column's sequence and all outputs at that clock edge. Enables in the following cycle are ignored, so the outputs are still low two edges after the write.
- R7: A change of `sel_i` takes effect only at a resync write. At any other time it has no effect on the outputs.
- R8: After a resync, columns that have the same source code produce identical `phi1_o`, `phi2_o` and `colclk_o` on every cycle.
- R9: A write to any other address, or a designated address presented with `bus_we_i` low, changes neither the outputs nor the stored selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_en_i | input | 4 | Single-cycle enables of the four sources |
| sel_i | input | 2*NUM_COLS | Source codes, 2 bits per column, taken at resync |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus write address |
| phi1_o | output | NUM_COLS | First phase per column |
| phi2_o | output | NUM_COLS | Second phase per column |
| colclk_o | output | NUM_COLS | Column clock, toggles on each phase fall |

## Verification
The checker watches every cycle for:
- overlap of the two phases;
- a phase rising directly after the other one was high;
- a column clock toggle that does not match a phase fall;
- an output changing without a preceding enable;
- outputs that are not cleared during the two edges that follow a resync write.

Some behaviours only the directed scenarios can show:
- which source a column follows;
- that a new selection waits for a resync;
- that writes to other addresses leave the state alone;
- that columns that were misaligned come back into step;
- that four enables make exactly one phase cycle.

A cycle model in the bench covers these.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned SRC_N = 4;
  localparam int unsigned SEL_W = $clog2(SRC_N);

  typedef enum logic [SEL_W-1:0] {
    SRC_SYS0 = 2'd0,
    SRC_SYS1 = 2'd1,
    SRC_AUX0 = 2'd2,
    SRC_AUX1 = 2'd3
  } src_sel_e;

  typedef logic [1:0] phase_cnt_t;
  localparam phase_cnt_t PH1_ST = 2'd1;
  localparam phase_cnt_t PH2_ST = 2'd3;
endpackage

// File: rtl/cg_resync_ctrl.sv
module cg_resync_ctrl #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ADDR_SEL = 'h60,
  parameter int unsigned ADDR_CAL = 'h63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              load_o,
  output logic              clear_o
);
  logic hit, hit_q;

  assign hit = bus_we_i && ((bus_addr_i == ADDR_W'(ADDR_SEL)) ||
                            (bus_addr_i == ADDR_W'(ADDR_CAL)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  assign load_o  = hit;
  // Clear spans the write edge and the one after it.
  assign clear_o = hit | hit_q;
endmodule

// File: rtl/cg_column.sv
module cg_column
  import cg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_en_i,
  input  src_sel_e         sel_i,
  input  logic             load_i,
  input  logic             clear_i,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             colclk_o
);
  src_sel_e   sel_q;
  phase_cnt_t cnt_q, cnt_nxt;
  logic       step;
  logic       phi1_q, phi2_q, colclk_q;

  assign step    = src_en_i[sel_q];
  assign cnt_nxt = cnt_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SRC_SYS0;
    else if (load_i) sel_q <= sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      phi1_q   <= 1'b0;
      phi2_q   <= 1'b0;
      colclk_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q    <= '0;
      phi1_q   <= 1'b0;
      phi2_q   <= 1'b0;
      colclk_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
      phi1_q <= (cnt_nxt == PH1_ST);
      phi2_q <= (cnt_nxt == PH2_ST);
      // A high phase leaves on this step: column clock flips with it.
      if (phi1_q || phi2_q) colclk_q <= ~colclk_q;
    end
  end

  assign phi1_o   = phi1_q;
  assign phi2_o   = phi2_q;
  assign colclk_o = colclk_q;
endmodule

// File: rtl/twophase_colclk.sv
module twophase_colclk
  import cg_pkg::*;
#(
  parameter int unsigned NUM_COLS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ADDR_SEL = 'h60,
  parameter int unsigned ADDR_CAL = 'h63
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SRC_N-1:0]          src_en_i,
  input  logic [NUM_COLS*SEL_W-1:0] sel_i,
  input  logic                      bus_we_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  output logic [NUM_COLS-1:0]       phi1_o,
  output logic [NUM_COLS-1:0]       phi2_o,
  output logic [NUM_COLS-1:0]       colclk_o
);
  logic rs_load, rs_clear;

  cg_resync_ctrl #(
    .ADDR_W  (ADDR_W),
    .ADDR_SEL(ADDR_SEL),
    .ADDR_CAL(ADDR_CAL)
  ) u_resync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_we_i  (bus_we_i),
    .bus_addr_i(bus_addr_i),
    .load_o    (rs_load),
    .clear_o   (rs_clear)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    cg_column u_col (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_en_i(src_en_i),
      .sel_i   (src_sel_e'(sel_i[c*SEL_W +: SEL_W])),
      .load_i  (rs_load),
      .clear_i (rs_clear),
      .phi1_o  (phi1_o[c]),
      .phi2_o  (phi2_o[c]),
      .colclk_o(colclk_o[c])
    );
  end
endmodule

// File: rtl/twophase_colclk_chk.sv
module twophase_colclk_chk #(
  parameter int unsigned NUM_COLS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ADDR_SEL = 'h60,
  parameter int unsigned ADDR_CAL = 'h63
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [3:0]          src_en_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [NUM_COLS-1:0] phi1_o,
  input logic [NUM_COLS-1:0] phi2_o,
  input logic [NUM_COLS-1:0] colclk_o
);
  logic wr_hit;
  assign wr_hit = bus_we_i && ((bus_addr_i == ADDR_W'(ADDR_SEL)) ||
                               (bus_addr_i == ADDR_W'(ADDR_CAL)));

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi1_o & phi2_o) == '0); // R4

  AST_RESYNC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (phi1_o == '0) && (phi2_o == '0) && (colclk_o == '0)); // R6

  AST_RESYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_hit) |=> (phi1_o == '0) && (phi2_o == '0) && (colclk_o == '0)); // R6

  AST_CHANGE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(phi1_o) || !$stable(phi2_o)) |-> ($past(|src_en_i) || $past(wr_hit))); // R3

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    AST_DEAD_BAND_P2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phi2_o[c]) |-> !$past(phi1_o[c])); // R4
    AST_DEAD_BAND_P1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phi1_o[c]) |-> !$past(phi2_o[c])); // R4
    AST_CLK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(colclk_o[c]) && !$past(wr_hit)) |-> ($fell(phi1_o[c]) || $fell(phi2_o[c]))); // R5
    AST_FALL_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($fell(phi1_o[c]) || $fell(phi2_o[c])) && !$past(wr_hit)) |-> !$stable(colclk_o[c])); // R5
  end
endmodule

bind twophase_colclk twophase_colclk_chk #(
  .NUM_COLS(NUM_COLS),
  .ADDR_W  (ADDR_W),
  .ADDR_SEL(ADDR_SEL),
  .ADDR_CAL(ADDR_CAL)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_en_i  (src_en_i),
  .bus_we_i  (bus_we_i),
  .bus_addr_i(bus_addr_i),
  .phi1_o    (phi1_o),
  .phi2_o    (phi2_o),
  .colclk_o  (colclk_o)
);

// File: tb/twophase_colclk_tb_top.sv
module twophase_colclk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC         = 4;
  localparam int AW         = 8;
  localparam logic [AW-1:0] A_SEL = 8'h60;
  localparam logic [AW-1:0] A_CAL = 8'h63;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    src_en_i = '0;
  logic [2*NC-1:0] sel_i = '0;
  logic          bus_we_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [NC-1:0] phi1_o, phi2_o, colclk_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state per column
  int m_sel [NC];
  int m_cnt [NC];
  logic [NC-1:0] m_p1, m_p2, m_ck;
  bit m_hold;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  twophase_colclk #(.NUM_COLS(NC), .ADDR_W(AW), .ADDR_SEL('h60), .ADDR_CAL('h63)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_en_i(src_en_i), .sel_i(sel_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .phi1_o(phi1_o), .phi2_o(phi2_o), .colclk_o(colclk_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin m_sel[c] = 0; m_cnt[c] = 0; end
    m_p1 = '0; m_p2 = '0; m_ck = '0; m_hold = 0;
  endtask

  // One clock cycle with the given enables and the current bus inputs.
  task automatic tick(input logic [3:0] en);
    bit hit;
    src_en_i = en;
    hit = bus_we_i && (bus_addr_i == A_SEL || bus_addr_i == A_CAL);
    for (int c = 0; c < NC; c++) begin
      if (hit) m_sel[c] = int'(sel_i[2*c +: 2]);
      if (hit || m_hold) begin
        m_cnt[c] = 0; m_p1[c] = 0; m_p2[c] = 0; m_ck[c] = 0;
      end else if (en[m_sel[c]]) begin
        if (m_p1[c] || m_p2[c]) m_ck[c] = ~m_ck[c];
        m_cnt[c] = (m_cnt[c] + 1) % 4;
        m_p1[c] = (m_cnt[c] == 1);
        m_p2[c] = (m_cnt[c] == 3);
      end
    end
    m_hold = hit;
    @(posedge clk_i);
    @(negedge clk_i);
    src_en_i = '0;
    check("R3 phi1 model", 32'(phi1_o), 32'(m_p1));
    check("R3 phi2 model", 32'(phi2_o), 32'(m_p2));
    check("R5 colclk model", 32'(colclk_o), 32'(m_ck));
  endtask

  task automatic bus_write(input logic [AW-1:0] addr, input logic we, input logic [3:0] en);
    bus_we_i = we; bus_addr_i = addr;
    tick(en);
    bus_we_i = 1'b0; bus_addr_i = '0;
  endtask

  task automatic t_reset();
    model_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 reset phi1", 32'(phi1_o), 0);
    check("R1 reset phi2", 32'(phi2_o), 0);
    check("R1 reset colclk", 32'(colclk_o), 0);
    rst_ni = 1'b1;
    tick(4'b0000);
    tick(4'b0010);  // code 0 after reset: source 1 ignored
    check("R1 idle after reset", 32'(phi1_o | phi2_o | colclk_o), 0);
  endtask

  task automatic t_divide();
    int rises = 0;
    logic prev;
    sel_i = {2'd3, 2'd2, 2'd1, 2'd0};
    bus_write(A_SEL, 1'b1, 4'b0000);
    tick(4'b0000);
    prev = phi1_o[0];
    for (int i = 0; i < 16; i++) begin
      tick(4'b0001);
      if (phi1_o[0] && !prev) rises++;
      prev = phi1_o[0];
      tick(4'b0000);
    end
    check("R3 four enables per phase cycle", rises, 4);
    check("R2 other columns idle", 32'(phi1_o[3:1] | phi2_o[3:1] | colclk_o[3:1]), 0);
    tick(4'b0100);  // aux source 0 drives column 2 only
    check("R2 column 2 follows code 2", 32'(phi1_o), 32'b0100);
  endtask

  task automatic t_deadband();
    logic [NC-1:0] p1_prev, p2_prev;
    p1_prev = phi1_o; p2_prev = phi2_o;
    for (int i = 0; i < 24; i++) begin
      tick(4'b1111);
      check("R4 no overlap", 32'(phi1_o & phi2_o), 0);
      check("R4 gap before phi2", 32'(phi2_o & ~p2_prev & p1_prev), 0);
      check("R4 gap before phi1", 32'(phi1_o & ~p1_prev & p2_prev), 0);
      p1_prev = phi1_o; p2_prev = phi2_o;
    end
  endtask

  task automatic t_colclk();
    int tog = 0;
    logic prev;
    bus_write(A_CAL, 1'b1, 4'b0000);
    tick(4'b0000);
    prev = colclk_o[0];
    for (int i = 0; i < 8; i++) begin
      tick(4'b0001);
      if (colclk_o[0] != prev) begin
        tog++;
        check("R5 toggle at phase fall", 32'(phi1_o[0] | phi2_o[0]), 0);
      end
      prev = colclk_o[0];
    end
    check("R5 toggles per 8 enables", tog, 4);
  endtask

  task automatic t_sel_ignored();
    sel_i = {2'd3, 2'd2, 2'd1, 2'd0};
    bus_write(A_SEL, 1'b1, 4'b0000);
    tick(4'b0000);
    sel_i = {2'd0, 2'd0, 2'd0, 2'd0};  // no write: must not apply
    tick(4'b0001);
    check("R7 column 1 keeps source 1", 32'(phi1_o), 32'b0001);
    tick(4'b0010);
    check("R7 column 1 steps on source 1", 32'(phi1_o), 32'b0011);
  endtask

  task automatic t_other_writes();
    logic [NC-1:0] p1, p2, ck;
    p1 = phi1_o; p2 = phi2_o; ck = colclk_o;
    bus_write(A_SEL + 8'd1, 1'b1, 4'b0000);
    check("R9 other address phi1", 32'(phi1_o), 32'(p1));
    check("R9 other address colclk", 32'(colclk_o), 32'(ck));
    bus_write(A_CAL, 1'b0, 4'b0000);
    check("R9 we low phi1", 32'(phi1_o), 32'(p1));
    check("R9 we low phi2", 32'(phi2_o), 32'(p2));
    tick(4'b0001);  // col0 still on src0, col1 still on src1
    check("R9 selection not loaded", 32'(phi1_o[1]), 32'(p1[1]));
  endtask

  task automatic t_realign();
    sel_i = {2'd3, 2'd2, 2'd1, 2'd0};
    bus_write(A_SEL, 1'b1, 4'b0000);
    tick(4'b0000);
    tick(4'b0001);
    repeat (3) tick(4'b0010);
    check("R8 misaligned before", 32'(phi1_o[1:0]), 32'b01);
    sel_i = {2'd3, 2'd2, 2'd0, 2'd0};
    bus_write(A_CAL, 1'b1, 4'b0011);
    check("R6 cleared at write", 32'(phi1_o | phi2_o | colclk_o), 0);
    tick(4'b0001);
    check("R6 enable ignored after write", 32'(phi1_o | phi2_o | colclk_o), 0);
    for (int i = 0; i < 10; i++) begin
      tick(4'b0001);
      check("R8 phi1 aligned", 32'(phi1_o[1]), 32'(phi1_o[0]));
      check("R8 phi2 aligned", 32'(phi2_o[1]), 32'(phi2_o[0]));
      check("R8 colclk aligned", 32'(colclk_o[1]), 32'(colclk_o[0]));
    end
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_divide();
    t_deadband();
    t_colclk();
    t_sel_ignored();
    t_other_writes();
    t_realign();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule